// File: doc/BRIEF.md
# Field-Memory Line Packer with Vertical Luma Filter

This block forms the write side of a picture-in-picture field store. It takes a time-multiplexed stream of 6-bit video samples that repeats luma, red-difference, luma, blue-difference. It keeps one line out of every group of three lines (large inset) or four lines (small inset). It can replace the luma of that kept line with a weighted average over the whole group. It then packs each run of six luma samples, together with one red-difference and one blue-difference sample, into six bytes. Each byte carries one luma value and a 2-bit slice of a chroma value. The bytes leave as a write strobe, an 8-bit data word and a linear address.

A field begins with a one-cycle `field_start` pulse. This pulse latches the size mode, rewinds the address and the line phase, and clears the stored-line count. Every line begins with a `line_start` pulse. The field state machine has three states. `F_IDLE` holds until the first field pulse (transition IDLE→CAPTURE). `F_CAPTURE` accepts samples; when the last group of the final stored line is packed it moves to `F_FULL` (CAPTURE→FULL), and a new field pulse restarts it (CAPTURE→CAPTURE). `F_FULL` ignores everything until the next field pulse (FULL→CAPTURE). The byte emitter has two states. `E_IDLE` waits for a complete group (IDLE→SEND). `E_SEND` puts out six bytes on consecutive cycles and returns after the sixth (SEND→IDLE).

Top module: `pip_line_packer`

## Requirements
- R1: After reset, and until the first `field_start`, `wr_en` stays low whatever the other inputs do.
- R2: With `big_mode`=1 latched at `field_start`, only the third line (phase 2) of each three-line group is written. With `big_mode`=0, only the fourth line (phase 3) of each four-line group is written. The first `line_start` after `field_start` opens phase 0.
- R3: Within a line, accepted samples are numbered from 0. Even numbers are luma. Of each twelve samples 12g..12g+11, only sample 12g+1 (red-difference) and sample 12g+3 (blue-difference) are kept as chroma; the other chroma samples are dropped.
- R4: The six luma values Y0..Y5 of a group are written in order as six bytes with the luma in bits 7:2. Bits 1:0 carry V[1:0], V[3:2], V[5:4] in bytes 0 to 2, and U[1:0], U[3:2], U[5:4] in bytes 3 to 5.
- R5: A line accepts exactly 2×Y_LARGE or 2×Y_SMALL valid samples, so it yields that many luma bytes. Further samples on the line are ignored, and cycles with `smp_valid` low are skipped.
- R6: In large mode with `vfilt_en`=1, the stored luma is (a + 2b + c + 2) >> 2, taken over the three lines of the group in order.
- R7: In small mode with `vfilt_en`=1, the stored luma is (a + b + c + d + 2) >> 2 over the four lines of the group.
- R8: With `vfilt_en`=0, the stored luma is that of the kept line unchanged. Chroma always comes from the kept line.
- R9: After H_LARGE+1 (large) or H_SMALL+1 (small) stored lines, nothing more is written until the next `field_start`.
- R10: `wr_addr` is 0 on the first write after `field_start` and goes up by one on each write.
- R11: While `freeze` is high, `wr_en` stays low and the address does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| field_start | input | 1 | One-cycle pulse at the start of an inset field |
| line_start | input | 1 | One-cycle pulse at the start of each source line |
| smp_valid | input | 1 | `smp_data` holds a sample this cycle |
| smp_data | input | 6 | Multiplexed sample, Y,V,Y,U order |
| big_mode | input | 1 | 1 = large inset (1 of 3 lines), 0 = small (1 of 4); latched at `field_start` |
| vfilt_en | input | 1 | Enables vertical luma averaging |
| freeze | input | 1 | Holds memory contents by suppressing writes |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | AW | Byte address, AW = clog2(max(Y)·(max(H)+1)) |
| wr_data | output | 8 | Packed byte |

## Verification
The bench builds the block with Y_LARGE=12, Y_SMALL=6, H_LARGE=2 and H_SMALL=1. A full field therefore needs only a dozen short lines, so the end-of-field cutoff (R9) is reached in every mode. The lines still hold two large groups or one small group, so each chroma choice and each packing slot is exercised. Both filter kernels, the unfiltered path, freeze, and traffic before the first field are each covered by a separate field.

// File: rtl/lp_pkg.sv
package lp_pkg;
    typedef enum logic [1:0] {F_IDLE, F_CAPTURE, F_FULL} field_st_t;
    typedef enum logic {E_IDLE, E_SEND} emit_st_t;
    localparam int SMP_W = 6;
endpackage

// File: rtl/lp_luma_vfilter.sv
module lp_luma_vfilter #(
    parameter int YMAX = 114,
    parameter int IW   = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          y_we,
    input  logic [IW-1:0] y_idx,
    input  logic [5:0]    y_in,
    input  logic [1:0]    phase,
    input  logic          big,
    input  logic          en,
    output logic [5:0]    y_out
);
    logic [7:0] acc [YMAX];
    logic [7:0] base, sum, rnd;
    logic       dbl;

    always_comb begin
        dbl   = big && (phase == 2'd1);
        base  = (phase == 2'd0) ? 8'd0 : acc[y_idx];
        sum   = base + (dbl ? {1'b0, y_in, 1'b0} : {2'b00, y_in});
        rnd   = sum + 8'd2;
        y_out = en ? rnd[7:2] : y_in;
    end

    always_ff @(posedge clk) begin
        if (y_we) acc[y_idx] <= sum;
    end

    // R6/R7: four weight units of a 6-bit value never exceed 252
    a_r6_sum_cap: assert property (@(posedge clk) disable iff (!rst_n)
        y_we |-> (sum <= 8'd252));
endmodule

// File: rtl/lp_group_packer.sv
module lp_group_packer
    import lp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_we,
    input  logic [3:0] gpos,
    input  logic [5:0] smp,
    input  logic [5:0] ylum,
    input  logic       freeze,
    output logic       out_vld,
    output logic [7:0] out_dat
);
    logic [5:0] yg [5];
    logic [5:0] ybuf [6];
    logic [5:0] v_q, u_q, vb, ub, csel;
    logic [2:0] bidx, kk;
    logic [1:0] slice;
    logic       load;
    emit_st_t   est, est_n;

    assign load = smp_we && (gpos == 4'd10);

    always_comb begin
        est_n = est;
        unique case (est)
            E_IDLE: if (load) est_n = E_SEND;
            E_SEND: if (bidx == 3'd5) est_n = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) est <= E_IDLE;
        else        est <= est_n;
    end

    always_ff @(posedge clk) begin
        if (smp_we) begin
            if (!gpos[0] && gpos != 4'd10) yg[gpos[3:1]] <= ylum;
            if (gpos == 4'd1) v_q <= smp;
            if (gpos == 4'd3) u_q <= smp;
        end
        if (load) begin
            for (int i = 0; i < 5; i++) ybuf[i] <= yg[i];
            ybuf[5] <= ylum;
            vb      <= v_q;
            ub      <= u_q;
        end
    end

    always_comb begin
        csel = (bidx < 3'd3) ? vb : ub;
        kk   = (bidx < 3'd3) ? bidx : bidx - 3'd3;
        unique case (kk)
            3'd0:    slice = csel[1:0];
            3'd1:    slice = csel[3:2];
            default: slice = csel[5:4];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bidx    <= '0;
            out_vld <= 1'b0;
            out_dat <= '0;
        end else begin
            if (load)                bidx <= '0;
            else if (est == E_SEND)  bidx <= bidx + 3'd1;
            out_vld <= (est == E_SEND) && !freeze;
            out_dat <= {ybuf[bidx], slice};
        end
    end

    // R4: a burst never runs past its sixth byte
    a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        (est == E_SEND) |-> (bidx <= 3'd5));
    // R11: a frozen cycle is never followed by a write
    a_r11_freeze_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(freeze) |-> !out_vld);
endmodule

// File: rtl/pip_line_packer.sv
module pip_line_packer
    import lp_pkg::*;
#(
    parameter int Y_LARGE = 114,
    parameter int Y_SMALL = 84,
    parameter int H_LARGE = 70,
    parameter int H_SMALL = 52,
    localparam int YMAX = (Y_LARGE > Y_SMALL) ? Y_LARGE : Y_SMALL,
    localparam int HMAX = (H_LARGE > H_SMALL) ? H_LARGE : H_SMALL,
    localparam int AW   = $clog2(YMAX * (HMAX + 1))
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          field_start,
    input  logic          line_start,
    input  logic          smp_valid,
    input  logic [5:0]    smp_data,
    input  logic          big_mode,
    input  logic          vfilt_en,
    input  logic          freeze,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);
    localparam int IW  = $clog2(YMAX);
    localparam int SPW = $clog2(2 * YMAX + 1);
    localparam int LW  = $clog2(HMAX + 2);

    field_st_t      fst, fst_n;
    logic           mode_q, line_act, accept, store_we, line_end;
    logic [1:0]     lph, nlast;
    logic [SPW-1:0] spos, spos_lim;
    logic [3:0]     gpos;
    logic [LW-1:0]  stored, hlim;
    logic [IW-1:0]  y_idx, y_last;
    logic [5:0]     y_f;
    logic [AW-1:0]  addr;

    always_comb begin
        nlast    = mode_q ? 2'd2 : 2'd3;
        spos_lim = mode_q ? SPW'(2 * Y_LARGE) : SPW'(2 * Y_SMALL);
        y_last   = mode_q ? IW'(Y_LARGE - 1) : IW'(Y_SMALL - 1);
        hlim     = mode_q ? LW'(H_LARGE + 1) : LW'(H_SMALL + 1);
        y_idx    = IW'(spos >> 1);
        accept   = (fst == F_CAPTURE) && line_act && smp_valid && (spos < spos_lim);
        store_we = accept && (lph == nlast);
        line_end = store_we && (gpos == 4'd10) && (y_idx == y_last);
    end

    always_comb begin
        fst_n = fst;
        unique case (fst)
            F_IDLE:    if (field_start) fst_n = F_CAPTURE;
            F_CAPTURE: if (field_start) fst_n = F_CAPTURE;
                       else if (line_end && (stored + LW'(1) == hlim)) fst_n = F_FULL;
            F_FULL:    if (field_start) fst_n = F_CAPTURE;
            default:   fst_n = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fst <= F_IDLE;
        else        fst <= fst_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0; lph <= '0; line_act <= 1'b0;
            spos <= '0; gpos <= '0; stored <= '0; addr <= '0;
        end else begin
            if (field_start) begin
                mode_q   <= big_mode;
                lph      <= big_mode ? 2'd2 : 2'd3;
                line_act <= 1'b0;
                spos     <= '0;
                stored   <= '0;
                addr     <= '0;
            end else begin
                if (line_start && fst == F_CAPTURE) begin
                    lph      <= (lph == nlast) ? 2'd0 : lph + 2'd1;
                    line_act <= 1'b1;
                    spos     <= '0;
                    gpos     <= '0;
                end else if (accept) begin
                    spos <= spos + SPW'(1);
                    gpos <= (gpos == 4'd11) ? 4'd0 : gpos + 4'd1;
                end
                if (line_end) stored <= stored + LW'(1);
                if (wr_en)    addr   <= addr + AW'(1);
            end
        end
    end

    lp_luma_vfilter #(.YMAX(YMAX), .IW(IW)) u_filt (
        .clk(clk), .rst_n(rst_n), .y_we(accept && !spos[0]), .y_idx(y_idx),
        .y_in(smp_data), .phase(lph), .big(mode_q), .en(vfilt_en), .y_out(y_f)
    );

    lp_group_packer u_pack (
        .clk(clk), .rst_n(rst_n), .smp_we(store_we), .gpos(gpos), .smp(smp_data),
        .ylum(y_f), .freeze(freeze), .out_vld(wr_en), .out_dat(wr_data)
    );

    assign wr_addr = addr;

    // R9: the full state is only reached with the stored-line quota met
    a_r9_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        (fst == F_FULL) |-> (stored == hlim));
    // R5: the sample index never passes the per-line quota
    a_r5_spos_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (fst == F_CAPTURE) |-> (spos <= spos_lim));
    // R2: line phase stays inside the group of the latched mode
    a_r2_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        (fst != F_IDLE) |-> (lph <= nlast));
    // R10: back-to-back writes use consecutive addresses
    a_r10_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en) && !$past(field_start)) |-> (wr_addr == $past(wr_addr) + AW'(1)));
    // R1: nothing is written before the first field
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (fst == F_IDLE && $past(fst) == F_IDLE) |-> !wr_en);
endmodule

// File: tb/pip_line_packer_tb.sv
`timescale 1ns/1ps
module pip_line_packer_tb;
    localparam int YL = 12, YS = 6, HL = 2, HS = 1;
    localparam int YMX = 12, HMX = 2;
    localparam int AW = $clog2(YMX * (HMX + 1));

    logic clk = 1'b0, rst_n = 1'b0;
    logic field_start = 0, line_start = 0, smp_valid = 0, big_mode = 0, vfilt_en = 0, freeze = 0;
    logic [5:0] smp_data = '0;
    logic wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0] wr_data;

    int total = 0, fails = 0, wcnt = 0;
    int cap_a [256];
    int cap_d [256];
    bit done = 0;

    always #2.5 clk = ~clk;

    pip_line_packer #(.Y_LARGE(YL), .Y_SMALL(YS), .H_LARGE(HL), .H_SMALL(HS)) u_dut (
        .clk(clk), .rst_n(rst_n), .field_start(field_start), .line_start(line_start),
        .smp_valid(smp_valid), .smp_data(smp_data), .big_mode(big_mode), .vfilt_en(vfilt_en),
        .freeze(freeze), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always @(negedge clk) if (wr_en && wcnt < 256) begin
        cap_a[wcnt] = int'(wr_addr);
        cap_d[wcnt] = int'(wr_data);
        wcnt++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int fv(int l, int p, int sd);
        return (l * 13 + p * 7 + sd * 3 + 5) % 64;
    endfunction

    function automatic int yexp(bit big, bit vf, int s, int i, int sd);
        int n = big ? 3 : 4;
        int l0 = s * n;
        if (!vf) return fv(l0 + n - 1, 2 * i, sd);
        if (big) return (fv(l0, 2*i, sd) + 2 * fv(l0+1, 2*i, sd) + fv(l0+2, 2*i, sd) + 2) >> 2;
        return (fv(l0, 2*i, sd) + fv(l0+1, 2*i, sd) + fv(l0+2, 2*i, sd) + fv(l0+3, 2*i, sd) + 2) >> 2;
    endfunction

    task automatic drive_lines(input int nlines, input int ycnt, input int sd);
        for (int l = 0; l < nlines; l++) begin
            line_start = 1; @(negedge clk); line_start = 0;
            for (int p = 0; p < 2 * ycnt + 2; p++) begin
                if (p == 5) begin smp_valid = 0; @(negedge clk); end
                smp_valid = 1; smp_data = 6'(fv(l, p, sd)); @(negedge clk);
            end
            smp_valid = 0; repeat (3) @(negedge clk);
        end
        repeat (12) @(negedge clk);
    endtask

    task automatic run_field(input bit big, input bit vf, input bit frz, input int nlines,
                             input int sd, input string tag);
        int ycnt = big ? YL : YS;
        int n = big ? 3 : 4;
        int lim = big ? HL + 1 : HS + 1;
        int ns = (nlines / n < lim) ? nlines / n : lim;
        int expn = frz ? 0 : ns * ycnt;
        wcnt = 0;
        big_mode = big; vfilt_en = vf; freeze = frz;
        field_start = 1; @(negedge clk); field_start = 0; @(negedge clk);
        drive_lines(nlines, ycnt, sd);
        chk(wcnt == expn, frz ? "R11 write count" : "R9 write count", wcnt, expn);
        for (int k = 0; k < wcnt && k < expn; k++) begin
            int s = k / ycnt, i = k % ycnt, g = i / 6, j = i % 6;
            int ln = s * n + n - 1;
            int c = (j < 3) ? fv(ln, 12*g + 1, sd) : fv(ln, 12*g + 3, sd);
            int eb = (yexp(big, vf, s, i, sd) << 2) | ((c >> (2 * (j % 3))) & 3);
            chk(cap_a[k] == k, "R10 address", cap_a[k], k);
            chk(cap_d[k] == eb, tag, cap_d[k], eb);
        end
    endtask

    task automatic t_reset();
        chk(wr_en == 1'b0, "R1 reset wr_en", int'(wr_en), 0);
        wcnt = 0;
        drive_lines(4, YL, 9);
        chk(wcnt == 0, "R1 no field yet", wcnt, 0);
    endtask

    task automatic t_large_plain();  run_field(1, 0, 0, 12, 1, "R4 R3 R8 large unfiltered"); endtask
    task automatic t_large_filt();   run_field(1, 1, 0, 9, 2, "R6 large filter");            endtask
    task automatic t_small_plain();  run_field(0, 0, 0, 10, 3, "R2 R5 small unfiltered");    endtask
    task automatic t_small_filt();   run_field(0, 1, 0, 8, 4, "R7 small filter");            endtask
    task automatic t_freeze();
        run_field(1, 0, 1, 9, 5, "R11 frozen");
        run_field(1, 0, 0, 6, 6, "R10 after freeze");
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_large_plain();
        t_large_filt();
        t_small_plain();
        t_small_filt();
        t_freeze();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule